// File: doc/BRIEF.md
# 1-Wire Reset and Presence Sequencer

This block runs the reset phase of a 1-Wire bus master. When the slot engine asks for a reset, it pulls the open-drain line low for the reset pulse and then releases it. It then samples the line once for a slave's presence response. It holds a busy indication until a minimum reset window, counted from the start of the pulse, has passed. On completion it raises a done strobe, and the result flags stay valid until the next request.

Timing is counted in ticks of a one-microsecond enable that is generated elsewhere. A mode input selects the normal timing or the overdrive timing, which is about ten times shorter. The mode is latched when a request is accepted.

The line may still be low once the reset pulse ends, either because a slave is signalling an alarm or because the line is shorted to ground. In that case the block waits a long time for the line to rise. If the line never rises, the block reports a short and ends the operation. If the line does rise, the block restarts its presence monitoring from that rising edge, including the idle-high recovery span after it.

Top module: `owr_reset_seq`

## Requirements
- R1: After reset, and after any reset during an operation, busy_o, bus_pull_o, done_o, presence_o and short_o are all 0.
- R2: A start_i seen while idle is accepted at that clock edge. From the next cycle busy_o is 1. bus_pull_o is 1 for exactly 480 ticks in normal mode, or 48 ticks in overdrive mode. The mode is the value of ovd_i latched at acceptance.
- R3: start_i is ignored while busy_o is 1: the done cycle and the flags of the running operation do not change.
- R4: On the first tick after release, a high line starts presence monitoring, with the release as the reference point. A low line starts the wait for the line to rise instead.
- R5: presence_o is set to the inverse of bus_i as seen on the 70th tick (normal) or the 8th tick (overdrive) after the reference point. It is cleared when a start is accepted and is otherwise held.
- R6: During the wait, a tick that sees the line high makes that tick the new reference point, and presence monitoring follows. If the line is low on 3840 consecutive ticks, counting the first tick after release, short_o goes to 1, presence_o stays 0, and the operation ends.
- R7: The operation ends on the first tick that has at least 960 ticks (normal) or 96 ticks (overdrive) since acceptance, and also at least 480 ticks (normal) or 48 ticks (overdrive) since the reference point. At that edge busy_o falls and done_o is 1 for exactly one cycle.
- R8: bus_pull_o is never 1 while busy_o is 0. Without ticks the operation does not advance: busy_o and bus_pull_o keep their values.
- R9: While idle and with no start, presence_o and short_o do not change, whatever bus_i does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a reset sequence |
| ovd_i | input | 1 | 1 selects overdrive timing, latched on acceptance |
| tick_i | input | 1 | One-microsecond enable |
| bus_i | input | 1 | Synchronized level of the 1-Wire line |
| bus_pull_o | output | 1 | 1 pulls the open-drain line low |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| presence_o | output | 1 | Presence (line low) seen at the sample point |
| short_o | output | 1 | Line stayed low through the whole wait |

## Verification
All results are counted in clock edges from the edge that accepts the start. The bench drives a tick on every cycle, so ticks and edges line up.

- **Pull-low pulse:** bus_pull_o and busy_o are registered, so they change one cycle after the deciding edge. The bench counts the pulled cycles at the falling clock edge.
- **Done strobe:** done_o appears in the cycle that follows the ending edge. That edge is the larger of the window length and the reference edge plus the post-release span.
- **Presence sample:** the sample at edge E_k sees the line level that the bench drove during cycle k-1. The expected presence therefore uses the reference edge plus the sample count minus one.
- **Short:** the short ends the operation at the 480 + 3840 edge.

The bench samples all outputs half a period after the edges and checks the flags after the strobe.

// File: rtl/owr_rstseq_pkg.sv
package owr_rstseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_RELCHK,
    ST_ALARM,
    ST_MON
  } rs_state_t;

  // mode selection of a timing value
  function automatic int unsigned mode_pick(input logic ovd,
                                            input int unsigned norm_v,
                                            input int unsigned ovd_v);
    return ovd ? ovd_v : norm_v;
  endfunction

  // span required after the reference point so the window covers recovery
  function automatic int unsigned post_span(input int unsigned win,
                                            input int unsigned low);
    return (win > low) ? win - low : 0;
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/owr_sat_cnt.sv
module owr_sat_cnt #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] nxt_o
);
  localparam logic [W-1:0] TOP = '1;

  assign nxt_o = (inc && (cnt_o != TOP)) ? cnt_o + 1'b1 : cnt_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_o <= '0;
    else if (clr) cnt_o <= '0;
    else          cnt_o <= nxt_o;
  end
endmodule

// File: rtl/owr_rstseq_ctrl.sv
module owr_rstseq_ctrl
  import owr_rstseq_pkg::*;
#(
  parameter int unsigned LOW_NORM_US = 480,
  parameter int unsigned LOW_OVD_US  = 48,
  parameter int unsigned WIN_NORM_US = 960,
  parameter int unsigned WIN_OVD_US  = 96,
  parameter int unsigned SMP_NORM_US = 70,
  parameter int unsigned SMP_OVD_US  = 8,
  parameter int unsigned ALARM_US    = 3840,
  parameter int unsigned W           = 12
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  input  logic      ovd_i,
  input  logic      tick_i,
  input  logic      bus_i,
  output rs_state_t st_o,
  output logic      ovd_q_o,
  output logic      ev_start_o,
  output logic      ev_release_o,
  output logic      ev_sample_o,
  output logic      ev_short_o,
  output logic      ev_done_o
);
  rs_state_t st, st_nxt;
  logic      ovd_q;
  logic      busy;
  logic      alarm_exit;
  logic      ph_clr;
  logic [W-1:0] ph_cnt, ph_nxt, tot_cnt, tot_nxt;
  logic [W-1:0] low_t, win_t, smp_t, post_t, alm_t;

  // timing values for the latched mode
  assign low_t  = W'(mode_pick(ovd_q, LOW_NORM_US, LOW_OVD_US));
  assign win_t  = W'(mode_pick(ovd_q, WIN_NORM_US, WIN_OVD_US));
  assign smp_t  = W'(mode_pick(ovd_q, SMP_NORM_US, SMP_OVD_US));
  assign post_t = W'(post_span(mode_pick(ovd_q, WIN_NORM_US, WIN_OVD_US),
                               mode_pick(ovd_q, LOW_NORM_US, LOW_OVD_US)));
  assign alm_t  = W'(ALARM_US);

  assign busy = (st != ST_IDLE);

  // named events
  assign ev_start_o   = (st == ST_IDLE) && start_i;
  assign ev_release_o = (st == ST_LOW) && tick_i && (ph_nxt == low_t);
  assign alarm_exit   = (st == ST_ALARM) && tick_i && bus_i;
  assign ev_short_o   = (st == ST_ALARM) && tick_i && !bus_i && (ph_nxt == alm_t);
  assign ev_sample_o  = (st == ST_MON) && tick_i && (ph_nxt == smp_t);
  assign ev_done_o    = (st == ST_MON) && tick_i && (ph_nxt >= post_t) &&
                        (tot_nxt >= win_t);

  assign ph_clr = ev_start_o || ev_release_o || alarm_exit;

  // phase counter: ticks since start, release or line rise
  owr_sat_cnt #(.W(W)) i_ph_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ph_clr),
    .inc   (tick_i && busy),
    .cnt_o (ph_cnt),
    .nxt_o (ph_nxt)
  );

  // window counter: ticks since acceptance
  owr_sat_cnt #(.W(W)) i_tot_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ev_start_o),
    .inc   (tick_i && busy),
    .cnt_o (tot_cnt),
    .nxt_o (tot_nxt)
  );

  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_IDLE:   if (ev_start_o) st_nxt = ST_LOW;
      ST_LOW:    if (ev_release_o) st_nxt = ST_RELCHK;
      ST_RELCHK: if (tick_i) st_nxt = bus_i ? ST_MON : ST_ALARM;
      ST_ALARM: begin
        if (alarm_exit)      st_nxt = ST_MON;
        else if (ev_short_o) st_nxt = ST_IDLE;
      end
      ST_MON:    if (ev_done_o) st_nxt = ST_IDLE;
      default:   st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      ovd_q <= 1'b0;
    end else begin
      st <= st_nxt;
      if (ev_start_o) ovd_q <= ovd_i;
    end
  end

  assign st_o    = st;
  assign ovd_q_o = ovd_q;

  // tot_cnt itself is only consumed through tot_nxt
  logic unused_tot;
  assign unused_tot = ^tot_cnt;
endmodule

// File: rtl/owr_rstseq_result.sv
module owr_rstseq_result (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_start,
  input  logic ev_sample,
  input  logic ev_short,
  input  logic ev_done,
  input  logic bus_i,
  output logic presence_o,
  output logic short_o,
  output logic done_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presence_o <= 1'b0;
      short_o    <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= ev_done || ev_short;
      if (ev_start) begin
        presence_o <= 1'b0;
        short_o    <= 1'b0;
      end else begin
        if (ev_sample) presence_o <= !bus_i;
        if (ev_short)  short_o    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/owr_reset_seq.sv
module owr_reset_seq
  import owr_rstseq_pkg::*;
#(
  parameter int unsigned LOW_NORM_US = 480,
  parameter int unsigned LOW_OVD_US  = 48,
  parameter int unsigned WIN_NORM_US = 960,
  parameter int unsigned WIN_OVD_US  = 96,
  parameter int unsigned SMP_NORM_US = 70,
  parameter int unsigned SMP_OVD_US  = 8,
  parameter int unsigned ALARM_US    = 3840
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic ovd_i,
  input  logic tick_i,
  input  logic bus_i,
  output logic bus_pull_o,
  output logic busy_o,
  output logic done_o,
  output logic presence_o,
  output logic short_o
);
  localparam int unsigned W = $clog2(max3(ALARM_US, WIN_NORM_US, WIN_OVD_US) + 2);

  rs_state_t st;
  logic      ovd_q;
  logic      ev_start, ev_release, ev_sample, ev_short, ev_done;

  owr_rstseq_ctrl #(
    .LOW_NORM_US (LOW_NORM_US),
    .LOW_OVD_US  (LOW_OVD_US),
    .WIN_NORM_US (WIN_NORM_US),
    .WIN_OVD_US  (WIN_OVD_US),
    .SMP_NORM_US (SMP_NORM_US),
    .SMP_OVD_US  (SMP_OVD_US),
    .ALARM_US    (ALARM_US),
    .W           (W)
  ) i_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .ovd_i        (ovd_i),
    .tick_i       (tick_i),
    .bus_i        (bus_i),
    .st_o         (st),
    .ovd_q_o      (ovd_q),
    .ev_start_o   (ev_start),
    .ev_release_o (ev_release),
    .ev_sample_o  (ev_sample),
    .ev_short_o   (ev_short),
    .ev_done_o    (ev_done)
  );

  owr_rstseq_result i_result (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_start   (ev_start),
    .ev_sample  (ev_sample),
    .ev_short   (ev_short),
    .ev_done    (ev_done),
    .bus_i      (bus_i),
    .presence_o (presence_o),
    .short_o    (short_o),
    .done_o     (done_o)
  );

  assign bus_pull_o = (st == ST_LOW);
  assign busy_o     = (st != ST_IDLE);
endmodule

// File: rtl/owr_reset_seq_chk.sv
module owr_reset_seq_chk
  import owr_rstseq_pkg::*;
#(
  parameter int unsigned LOW_NORM_US = 480,
  parameter int unsigned LOW_OVD_US  = 48,
  parameter int unsigned WIN_NORM_US = 960,
  parameter int unsigned WIN_OVD_US  = 96
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic tick_i,
  input logic bus_pull_o,
  input logic busy_o,
  input logic done_o,
  input logic presence_o,
  input logic short_o,
  input logic ovd_q,
  input logic ev_sample
);
  logic [15:0] pull_ticks, busy_ticks;

  // independent tick counts for the windows
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pull_ticks <= '0;
      busy_ticks <= '0;
    end else begin
      if (start_i && !busy_o)           pull_ticks <= '0;
      else if (bus_pull_o && tick_i)    pull_ticks <= pull_ticks + 1'b1;
      if (!busy_o)                      busy_ticks <= '0;
      else if (tick_i && busy_ticks != 16'hFFFF) busy_ticks <= busy_ticks + 1'b1;
    end
  end

  // R2
  pull_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_pull_o) && busy_o |->
      pull_ticks == 16'(mode_pick(ovd_q, LOW_NORM_US, LOW_OVD_US)));

  // R8
  pull_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_pull_o |-> busy_o);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  done_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && $past(busy_o));

  // R7
  min_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !short_o |->
      busy_ticks >= 16'(mode_pick(ovd_q, WIN_NORM_US, WIN_OVD_US)));

  // R6
  short_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    short_o |-> !presence_o);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !start_i |=> $stable(presence_o) && $stable(short_o));

  // R5
  sample_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sample |-> !bus_pull_o);
endmodule

bind owr_reset_seq owr_reset_seq_chk #(
  .LOW_NORM_US (LOW_NORM_US),
  .LOW_OVD_US  (LOW_OVD_US),
  .WIN_NORM_US (WIN_NORM_US),
  .WIN_OVD_US  (WIN_OVD_US)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .tick_i     (tick_i),
  .bus_pull_o (bus_pull_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .presence_o (presence_o),
  .short_o    (short_o),
  .ovd_q      (ovd_q),
  .ev_sample  (ev_sample)
);

// File: tb/test_owr_reset_seq.sv
module test_owr_reset_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic ovd_i = 1'b0;
  logic tick_i = 1'b1;
  logic bus_i;
  logic bus_pull_o, busy_o, done_o, presence_o, short_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int c = 0;
  logic arm = 1'b0;

  // bus model state
  logic act = 1'b0;
  logic idle_low = 1'b0;
  int   m_low = 480;
  int   m_a = 0;
  int   m_p0 = 0;
  int   m_plen = 0;

  localparam int NV = 13;
  // ovd, low hold after release, presence offset, presence length, extra start cycle
  localparam int VEC [NV][5] = '{
    '{0, 0,    20, 120, -1},
    '{0, 0,    0,  0,   -1},
    '{0, 0,    15, 40,  -1},
    '{1, 0,    2,  10,  -1},
    '{1, 0,    0,  0,   -1},
    '{0, 200,  20, 100, -1},
    '{0, 100,  0,  0,   -1},
    '{0, 4000, 0,  0,   -1},
    '{1, 50,   3,  10,  -1},
    '{1, 5000, 0,  0,   -1},
    '{0, 3839, 0,  0,   -1},
    '{0, 3840, 0,  0,   -1},
    '{0, 1,    15, 200, 300}
  };

  owr_reset_seq i_owr_reset_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .ovd_i      (ovd_i),
    .tick_i     (tick_i),
    .bus_i      (bus_i),
    .bus_pull_o (bus_pull_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .presence_o (presence_o),
    .short_o    (short_o)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (arm) c <= 0;
    else     c <= c + 1;
  end

  always_comb begin
    int rise;
    bus_i = 1'b1;
    rise = m_low + m_a;
    if (bus_pull_o) bus_i = 1'b0;
    if (idle_low) bus_i = 1'b0;
    if (act) begin
      if (m_a > 0 && c >= m_low && c < m_low + m_a) bus_i = 1'b0;
      if (m_plen > 0 && c >= rise + m_p0 && c < rise + m_p0 + m_plen) bus_i = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // launch a sequence: accepted at the next posedge (edge E0)
  task automatic launch(input int ovd);
    @(negedge clk);
    ovd_i = ovd[0];
    start_i = 1'b1;
    arm = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    arm = 1'b0;
    ovd_i = 1'b0;
  endtask

  task automatic run_vec(input int k);
    int ovd, a, p0, plen, xs;
    int low, win, smp, post, refe, samp, exp_done, exp_pres, exp_short;
    int pulls, dcount, dc;
    string tag;
    ovd = VEC[k][0]; a = VEC[k][1]; p0 = VEC[k][2]; plen = VEC[k][3]; xs = VEC[k][4];
    low  = ovd ? 48 : 480;
    win  = ovd ? 96 : 960;
    smp  = ovd ? 8 : 70;
    post = win - low;
    exp_short = 0;
    exp_pres  = 0;
    if (a >= 3840) begin
      exp_short = 1;
      exp_done  = low + 3840;
    end else begin
      refe = (a > 0) ? low + a + 1 : low;
      samp = refe + smp - 1;
      exp_done = (win > refe + post) ? win : refe + post;
      if (plen > 0 && samp >= low + a + p0 && samp < low + a + p0 + plen) exp_pres = 1;
    end
    m_low = low; m_a = a; m_p0 = p0; m_plen = plen; act = 1'b1;
    pulls = 0; dcount = 0; dc = -1;
    launch(ovd);
    pulls = bus_pull_o ? 1 : 0;
    for (int n = 0; n < 6000; n++) begin
      if (c >= exp_done + 3) break;
      @(negedge clk);
      if (bus_pull_o) pulls++;
      if (done_o) begin dcount++; dc = c; end
      if (xs >= 0 && c == xs) start_i = 1'b1;
      else start_i = 1'b0;
    end
    start_i = 1'b0;
    tag = (xs >= 0) ? "R3 R7" : ((a > 0) ? "R4 R7" : "R7");
    chk(dcount == 1 && dc == exp_done, tag, dc, exp_done);
    chk(pulls == low, "R2", pulls, low);
    chk(presence_o == exp_pres[0], (a > 0) ? "R5 R6" : "R5", int'(presence_o), exp_pres);
    chk(short_o == exp_short[0], "R6", int'(short_o), exp_short);
    act = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        errors++;
        $display("FAIL R7: watchdog expired actual=%0d expected=%0d", cyc, 190000);
        summary();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({busy_o, bus_pull_o, done_o, presence_o, short_o} == 5'b0, "R1",
        int'({busy_o, bus_pull_o, done_o, presence_o, short_o}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int k = 0; k < NV; k++) run_vec(k);

    // R5: a new start clears the presence flag
    m_low = 480; m_a = 0; m_p0 = 20; m_plen = 100; act = 1'b1;
    launch(0);
    repeat (600) @(negedge clk);
    act = 1'b0;
    while (busy_o) @(negedge clk);
    chk(presence_o == 1'b1, "R5", int'(presence_o), 1);
    m_plen = 0;
    act = 1'b1;
    launch(0);
    chk(presence_o == 1'b0, "R5", int'(presence_o), 0);
    while (busy_o) @(negedge clk);
    act = 1'b0;
    repeat (2) @(negedge clk);

    // R9: flags hold while idle with the line low
    idle_low = 1'b1;
    repeat (40) @(negedge clk);
    chk(presence_o == 1'b0 && short_o == 1'b0 && !busy_o, "R9",
        int'({presence_o, short_o, busy_o}), 0);
    idle_low = 1'b0;
    repeat (2) @(negedge clk);

    // R8: no ticks, no progress
    m_low = 480; m_a = 0; m_plen = 0; act = 1'b1;
    tick_i = 1'b0;
    launch(0);
    repeat (1500) @(negedge clk);
    chk(busy_o && bus_pull_o, "R8", int'({busy_o, bus_pull_o}), 3);
    tick_i = 1'b1;
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      if (!busy_o) break;
    end
    chk(!busy_o && !bus_pull_o, "R8", int'({busy_o, bus_pull_o}), 0);

    // R1: reset in the middle of an operation
    launch(0);
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk({busy_o, bus_pull_o, done_o, presence_o, short_o} == 5'b0, "R1",
        int'({busy_o, bus_pull_o, done_o, presence_o, short_o}), 0);
    rst_n = 1'b1;
    act = 1'b0;
    repeat (3) @(negedge clk);
    summary();
  end
endmodule